// File: doc/BRIEF.md
# Flash Bus Write Guard with Identifier Readout

This block is the bus-facing front end of a byte-wide flash device with eight equal sectors. It runs on a fast sampling clock. It samples the active-low chip-select, write and output-enable strobes, and each strobe must hold a new level for a set number of consecutive samples before the block acts on it. From the filtered strobes the block decides when a real write cycle happens. At the end of that cycle it presents the latched address and data to the command logic behind it for one clock.

Writes are refused while the supply-good flag is low. A strobe pattern that already looks like a write when reset is released is never accepted as a write. The block keeps a read mode with two states. In array mode, reads return the external array data. In identifier mode, reads return a manufacturer code, a device code, or the protection state of the sector that the top address bits select. An external command decoder switches between the two modes with two single-cycle inputs.

Top module: `flash_bus_front`

## Requirements
- R1: A write is accepted only while the filtered strobes show chip-select low, write low and output-enable high at the same time. If output-enable stays low for the whole cycle, no write results.
- R2: A strobe change must be held for at least GLITCH_N consecutive clock samples before it takes effect. A low pulse on chip-select and write that lasts GLITCH_N-1 samples produces no write. One that lasts GLITCH_N samples produces one write.
- R3: While supply_ok is low, no write is produced and the read mode is forced to array. Once supply_ok returns and the strobes go idle, writes are accepted again.
- R4: If a write pattern is already present when reset is released, its end does not produce a write. The next complete write cycle after the strobes go idle is accepted.
- R5: At the end of each accepted cycle, wr_valid is high for exactly one clock. In that clock, wr_addr and wr_data hold the addr and din values present when the cycle ended.
- R6: In identifier mode, a read with addr[6]=0 and addr[1:0]=00 returns 01h.
- R7: In identifier mode, a read with addr[6]=0 and addr[1:0]=01 returns A4h.
- R8: In identifier mode, a read with addr[6]=0 and addr[1:0]=10 returns 01h when sect_prot[addr[18:16]] is 1 and 00h when it is 0.
- R9: After reset, the block is in array mode and rdata shows array_rdata one clock later. rdata is 00h while reset is held.
- R10: A pulse on id_enter selects identifier mode. A pulse on read_reset returns the block to array mode, and read_reset wins when both are high in the same clock.
- R11: In identifier mode, the address bits outside addr[18:16], addr[6] and addr[1:0] do not affect the result. addr[6]=1, or addr[1:0]=11, returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| ce_n | input | 1 | Chip-select strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| addr | input | 19 | Byte address |
| din | input | 8 | Write data |
| supply_ok | input | 1 | High while the supply is above the lockout level |
| sect_prot | input | 8 | Protection bit for each sector |
| id_enter | input | 1 | Pulse from the command decoder that selects identifier mode |
| read_reset | input | 1 | Pulse from the command decoder that returns to array mode |
| array_rdata | input | 8 | Data from the array for array-mode reads |
| wr_valid | output | 1 | One-clock pulse at the end of an accepted write |
| wr_addr | output | 19 | Address latched for the write |
| wr_data | output | 8 | Data latched for the write |
| rdata | output | 8 | Registered read data |

## Verification
The bench uses the default GLITCH_N of 3, eight sectors and the 19-bit address. With these values, a two-sample pulse and a three-sample pulse fall on either side of the filter threshold, so both the rejected case and the accepted case are tested. The eight sector bits are few enough that the bench reads the protection state of every sector against a mixed bit pattern. Power-up with the write pattern already present is tested by holding the strobes low through the release of reset.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   // strobe vector positions
   localparam int STB_CE = 0;
   localparam int STB_WE = 1;
   localparam int STB_OE = 2;
   localparam int STB_N  = 3;

   typedef enum logic [1:0] {
      IDSEL_MFR  = 2'b00,
      IDSEL_DEV  = 2'b01,
      IDSEL_PROT = 2'b10,
      IDSEL_NONE = 2'b11
   } idsel_e;

   function automatic logic write_pattern(input logic [STB_N-1:0] stb);
      return ~stb[STB_CE] & ~stb[STB_WE] & stb[STB_OE];
   endfunction
endpackage

// File: rtl/fbf_strobe_filter.sv
module fbf_strobe_filter #(
   parameter int GLITCH_N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic sample_n,
   output logic filt_n
);
   localparam int CNT_W = (GLITCH_N < 2) ? 1 : $clog2(GLITCH_N);

   logic [CNT_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_n <= 1'b1;
         filt_n   <= 1'b1;
         run_cnt  <= '0;
      end else begin
         sample_n <= pin_n;
         if (sample_n == filt_n) begin
            run_cnt <= '0;
         end else if (run_cnt == CNT_W'(GLITCH_N - 1)) begin
            filt_n  <= sample_n;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   AST_FILT_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_n != $past(filt_n)) |-> ($past(sample_n) == filt_n)); // R2
endmodule

// File: rtl/fbf_write_qual.sv
module fbf_write_qual
   import fbf_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STB_N-1:0]  stb_filt,
   input  logic [STB_N-1:0]  stb_sample,
   input  logic              supply_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   logic active, raw_active;
   logic primed, armed, in_win;

   assign active     = write_pattern(stb_filt);
   assign raw_active = write_pattern(stb_sample);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed   <= 1'b0;
         armed    <= 1'b0;
         in_win   <= 1'b0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         primed   <= 1'b1;
         wr_valid <= 1'b0;
         if (!supply_ok) begin
            armed  <= 1'b0;
            in_win <= 1'b0;
         end else begin
            if (primed && !active && !raw_active) armed <= 1'b1;
            if (active && !in_win && armed) begin
               in_win <= 1'b1;
               armed  <= 1'b0;
            end else if (in_win && !active) begin
               in_win   <= 1'b0;
               wr_valid <= 1'b1;
               wr_addr  <= addr;
               wr_data  <= din;
            end
         end
      end
   end

   AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid); // R5
   AST_WR_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(supply_ok)); // R3
endmodule

// File: rtl/fbf_id_read.sv
module fbf_id_read
   import fbf_pkg::*;
#(
   parameter int             DATA_W   = 8,
   parameter int             SECT_W   = 3,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h01,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'hA4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                id_mode,
   input  logic                a6,
   input  logic [1:0]          a_lo,
   input  logic [SECT_W-1:0]   sect_sel,
   input  logic [(1<<SECT_W)-1:0] sect_prot,
   input  logic [DATA_W-1:0]   array_rdata,
   output logic [DATA_W-1:0]   rdata
);
   idsel_e            sel;
   logic [DATA_W-1:0] id_word;

   always_comb begin
      sel = a6 ? IDSEL_NONE : idsel_e'(a_lo);
      unique case (sel)
         IDSEL_MFR:  id_word = MFR_CODE;
         IDSEL_DEV:  id_word = DEV_CODE;
         IDSEL_PROT: id_word = {{(DATA_W-1){1'b0}}, sect_prot[sect_sel]};
         default:    id_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= id_mode ? id_word : array_rdata;
   end

   AST_ID_MFR: assert property (@(posedge clk) disable iff (!rst_n)
      (id_mode && !a6 && a_lo == 2'b00) |=> (rdata == MFR_CODE)); // R6
   AST_ID_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      (id_mode && !a6 && a_lo == 2'b01) |=> (rdata == DEV_CODE)); // R7
   AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !id_mode |=> (rdata == $past(array_rdata))); // R9
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
   import fbf_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int SECT_W   = 3,
   parameter int GLITCH_N = 3,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h01,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'hA4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              supply_ok,
   input  logic [(1<<SECT_W)-1:0] sect_prot,
   input  logic              id_enter,
   input  logic              read_reset,
   input  logic [DATA_W-1:0] array_rdata,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rdata
);
   localparam int SECT_LSB = ADDR_W - SECT_W;

   generate
      if (GLITCH_N < 1)       begin : g_chk_glitch $error("GLITCH_N must be at least 1"); end
      if (SECT_W < 1 || SECT_LSB < 7) begin : g_chk_sect $error("sector bits overlap identifier bits"); end
      if (DATA_W < 2)         begin : g_chk_data $error("DATA_W too small"); end
   endgenerate

   logic [STB_N-1:0] pins_n, stb_sample, stb_filt;
   logic             id_mode;

   assign pins_n[STB_CE] = ce_n;
   assign pins_n[STB_WE] = we_n;
   assign pins_n[STB_OE] = oe_n;

   for (genvar gi = 0; gi < STB_N; gi++) begin : g_filt
      fbf_strobe_filter #(.GLITCH_N(GLITCH_N)) u_filt (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_n    (pins_n[gi]),
         .sample_n (stb_sample[gi]),
         .filt_n   (stb_filt[gi])
      );
   end

   fbf_write_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wq (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb_filt   (stb_filt),
      .stb_sample (stb_sample),
      .supply_ok  (supply_ok),
      .addr       (addr),
      .din        (din),
      .wr_valid   (wr_valid),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           id_mode <= 1'b0;
      else if (!supply_ok)  id_mode <= 1'b0;
      else if (read_reset)  id_mode <= 1'b0;
      else if (id_enter)    id_mode <= 1'b1;
   end

   fbf_id_read #(
      .DATA_W(DATA_W), .SECT_W(SECT_W),
      .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .id_mode     (id_mode),
      .a6          (addr[6]),
      .a_lo        (addr[1:0]),
      .sect_sel    (addr[ADDR_W-1:SECT_LSB]),
      .sect_prot   (sect_prot),
      .array_rdata (array_rdata),
      .rdata       (rdata)
   );

   AST_LOCKOUT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !id_mode); // R3
   AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      read_reset |=> !id_mode); // R10
endmodule

// File: tb/flash_bus_front_bench.sv
module flash_bus_front_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ce_n, we_n, oe_n;
   logic [18:0] addr;
   logic [7:0]  din;
   logic        supply_ok;
   logic [7:0]  sect_prot;
   logic        id_enter, read_reset;
   logic [7:0]  array_rdata;
   logic        wr_valid;
   logic [18:0] wr_addr;
   logic [7:0]  wr_data;
   logic [7:0]  rdata;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   logic [18:0] last_a;
   logic [7:0]  last_d;
   logic        prev_v = 1'b0;
   int          long_pulse = 0;

   always #2 clk = ~clk;

   flash_bus_front u_flash_bus_front (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .supply_ok(supply_ok), .sect_prot(sect_prot),
      .id_enter(id_enter), .read_reset(read_reset), .array_rdata(array_rdata),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .rdata(rdata)
   );

   always @(negedge clk) begin
      if (wr_valid) begin
         wr_cnt++;
         last_a = wr_addr;
         last_d = wr_data;
         if (prev_v) long_pulse++;
      end
      prev_v = wr_valid;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(input logic [18:0] a, input logic [7:0] d, input int len, input logic oe_val);
      @(negedge clk);
      addr = a; din = d; oe_n = oe_val; ce_n = 1'b0; we_n = 1'b0;
      cyc(len);
      ce_n = 1'b1; we_n = 1'b1;
      cyc(12);
      oe_n = 1'b1;
   endtask

   task automatic id_read(input logic [18:0] a, input string req, input logic [7:0] exp);
      @(negedge clk);
      addr = a;
      cyc(1);
      check(req, rdata, exp);
   endtask

   task automatic enter_id();
      @(negedge clk); id_enter = 1'b1;
      cyc(1); id_enter = 1'b0;
   endtask

   task automatic t_reset();
      int c0;
      rst_n = 1'b0;
      cyc(3);
      check("R9 reset rdata", rdata, 8'h00);
      check("R5 reset wr_valid", wr_valid, 1'b0);
      rst_n = 1'b1;
      cyc(2);
      array_rdata = 8'h5A;
      addr = 19'h00000;
      cyc(1);
      check("R9 array read after reset", rdata, 8'h5A);
      c0 = wr_cnt;
      check("R9 no spurious write", wr_cnt - c0, 0);
   endtask

   task automatic t_write_basic();
      int c0 = wr_cnt;
      strobe(19'h5_1234, 8'hC3, 5, 1'b1);
      check("R5 one write", wr_cnt - c0, 1);
      check("R5 addr", last_a, 19'h5_1234);
      check("R5 data", last_d, 8'hC3);
      check("R5 single cycle pulse", long_pulse, 0);
   endtask

   task automatic t_oe_inhibit();
      int c0 = wr_cnt;
      strobe(19'h0_0042, 8'h11, 6, 1'b0);
      check("R1 oe low inhibits", wr_cnt - c0, 0);
      strobe(19'h0_0043, 8'h22, 6, 1'b1);
      check("R1 write after oe inhibit", wr_cnt - c0, 1);
      check("R1 data", last_d, 8'h22);
   endtask

   task automatic t_glitch();
      int c0 = wr_cnt;
      strobe(19'h1_0000, 8'h33, 2, 1'b1);
      check("R2 short pulse rejected", wr_cnt - c0, 0);
      strobe(19'h1_0001, 8'h44, 3, 1'b1);
      check("R2 threshold pulse accepted", wr_cnt - c0, 1);
      check("R2 data", last_d, 8'h44);
   endtask

   task automatic t_supply();
      int c0;
      enter_id();
      id_read(19'h0, "R6 mfr before lockout", 8'h01);
      @(negedge clk); supply_ok = 1'b0;
      c0 = wr_cnt;
      strobe(19'h2_0000, 8'h55, 6, 1'b1);
      check("R3 no write in lockout", wr_cnt - c0, 0);
      @(negedge clk); supply_ok = 1'b1; array_rdata = 8'h6B;
      id_read(19'h0, "R3 mode forced array", 8'h6B);
      cyc(4);
      strobe(19'h2_0001, 8'h66, 6, 1'b1);
      check("R3 write after supply returns", wr_cnt - c0, 1);
   endtask

   task automatic t_powerup();
      int c0;
      @(negedge clk);
      rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      addr = 19'h3_0000; din = 8'h77;
      cyc(3);
      c0 = wr_cnt;
      rst_n = 1'b1;
      cyc(10);
      ce_n = 1'b1; we_n = 1'b1;
      cyc(12);
      check("R4 power-up pattern ignored", wr_cnt - c0, 0);
      strobe(19'h3_0001, 8'h78, 5, 1'b1);
      check("R4 next write accepted", wr_cnt - c0, 1);
      check("R4 data", last_d, 8'h78);
   endtask

   task automatic t_autoselect();
      sect_prot = 8'b1010_0110;
      enter_id();
      id_read(19'h0_0000, "R6 mfr code", 8'h01);
      id_read(19'h0_0001, "R7 device code", 8'hA4);
      for (int s = 0; s < 8; s++) begin
         id_read({s[2:0], 16'h0002}, "R8 sector protect", {7'b0, sect_prot[s]});
      end
      id_read(19'h0_FFBC, "R11 dont care bits mfr", 8'h01);
      id_read(19'h7_8F3D, "R11 dont care bits dev", 8'hA4);
      id_read(19'h0_0040, "R11 a6 high", 8'h00);
      id_read(19'h0_0003, "R11 a1a0 = 11", 8'h00);
   endtask

   task automatic t_modes();
      array_rdata = 8'h9E;
      @(negedge clk); read_reset = 1'b1;
      cyc(1); read_reset = 1'b0;
      id_read(19'h0_0001, "R10 read_reset to array", 8'h9E);
      enter_id();
      id_read(19'h0_0001, "R10 id_enter selects id", 8'hA4);
      @(negedge clk); read_reset = 1'b1; id_enter = 1'b1;
      cyc(1); read_reset = 1'b0; id_enter = 1'b0;
      id_read(19'h0_0001, "R10 read_reset wins", 8'h9E);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      addr = '0; din = '0; supply_ok = 1'b1; sect_prot = '0;
      id_enter = 1'b0; read_reset = 1'b0; array_rdata = '0;
      rst_n = 1'b0;
      t_reset();
      t_write_basic();
      t_oe_inhibit();
      t_glitch();
      t_supply();
      t_autoselect();
      t_modes();
      t_powerup();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule